// File: doc/BRIEF.md
# Disciplined Oscillator Status Telemetry

This block reports the state of a frequency-disciplining loop as plain ASCII text on a serial line. When the loop controller signals that a new averaging interval has closed, the block takes a snapshot of three values and sends them as three text lines. The three values are the accumulated phase count, the upper sixteen bits of the oscillator control word, and a packed status number. Each line is a zero-padded five-digit decimal number followed by carriage return and line feed. A host terminal can log the lines directly and plot them without any parsing beyond reading integers.

The status number packs one field into each decimal digit. The units digit is the filter mode, the tens digit is set when the deglitcher discarded a sample, and the hundreds digit is set when the loop looks unlocked. A single sequential binary-to-decimal converter is shared by the three values. A bit-serial transmitter sends each character as 8N1.

The block also drives a front-panel activity indicator. The indicator lights for a fixed time after each rising edge of the one-pulse-per-second input, so it blinks while pulses keep arriving and stays dark when they stop.

Top module: `osc_telemetry`

## Requirements
- R1: After reset the serial output `txd` is high (line idle) and `heartbeat` is low.
- R2: Each accepted report produces exactly three lines, in the order phase, control word, status. Each line is seven bytes: five ASCII digits (0x30 to 0x39), most significant digit first and zero-padded, then 0x0D, then 0x0A.
- R3: The first line is `phase_count` printed as an unsigned decimal from 00000 to 65535.
- R4: The second line is `dac_code[DAC_W-1:DAC_W-16]` printed as an unsigned decimal from 00000 to 65535.
- R5: The third line is `filt_mode + 100*unlocked + 10*deglitched`. The units digit is the mode from 0 to 7, the tens digit is the deglitch flag and the hundreds digit is the unlock flag. The two leading digits are always 0.
- R6: Every byte is sent 8N1: one low start bit, eight data bits LSB first, one high stop bit, each bit BAUD_DIV clock cycles long. `txd` is high whenever no frame is in progress.
- R7: The three values are captured in the clock cycle where `report_req` is high. Input changes after that cycle do not alter the lines of that report.
- R8: A `report_req` that arrives while a report is being sent is held in a single pending slot and sent right after the current report. A further request before the pending one starts replaces it, so only the latest is sent.
- R9: With no `report_req`, no byte is sent and `txd` stays high.
- R10: A rising edge on `pps` makes `heartbeat` high for exactly HB_ON_CYC cycles, starting the cycle after the edge is sampled.
- R11: A rising edge on `pps` while `heartbeat` is high restarts the HB_ON_CYC window. A `pps` held high produces only one window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| report_req | input | 1 | One-cycle request to report the current values |
| phase_count | input | 16 | Accumulated phase count for the last interval |
| dac_code | input | DAC_W | Oscillator control word (upper 16 bits are reported) |
| filt_mode | input | 3 | Filter mode setting, 0 to 7 |
| unlocked | input | 1 | Loop appears unlocked |
| deglitched | input | 1 | A sample was discarded in the interval |
| pps | input | 1 | One-pulse-per-second input, synchronous to clk |
| txd | output | 1 | Serial 8N1 text output |
| heartbeat | output | 1 | Activity indicator drive |

## Verification
The bench decodes the serial line itself and checks every line against values it computes arithmetically. It sweeps all 32 combinations of mode, unlock and deglitch, so a status digit placed in the wrong position or a missing offset shows up as a wrong number. It sends the extremes 0, 9, 65535 and an all-ones control word to catch a converter that drops a carry or loses leading zeros, and a wrong bit time or bit order shows up as framing errors or garbled bytes. It also queues requests during a message, where a design without a pending slot would lose a report and one without overwrite would send a stale one. It changes the inputs after each request, which exposes capture at the wrong time. It checks the exact number of cycles the indicator stays high for single, retriggered and held pulses, which catches a level-sensitive or non-retriggering stretch.

// File: rtl/telem_pkg.sv
package telem_pkg;
    localparam int VAL_W    = 16;
    localparam int NUM_DIG  = 5;
    localparam int NUM_VALS = 3;
    localparam int LINE_LEN = NUM_DIG + 2;
    localparam int BCD_W    = 4 * NUM_DIG;

    localparam logic [7:0] ASC_ZERO = 8'h30;
    localparam logic [7:0] ASC_CR   = 8'h0D;
    localparam logic [7:0] ASC_LF   = 8'h0A;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CONV,
        SQ_WAIT,
        SQ_CHAR
    } seq_state_e;
endpackage

// File: rtl/telem_bin2dec.sv
module telem_bin2dec #(
    parameter int BIN_W = 16,
    parameter int DIG   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [BIN_W-1:0]   bin_i,
    output logic               done_o,
    output logic [4*DIG-1:0]   bcd_o
);
    localparam int BCD_W = 4 * DIG;
    localparam int CNT_W = $clog2(BIN_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [BIN_W-1:0] bin;
        logic [BCD_W-1:0] bcd;
    } b2d_t;

    b2d_t q, d;
    logic [BCD_W-1:0] adj;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        adj    = q.bcd;
        // add three to every digit of five or more before shifting
        for (int k = 0; k < DIG; k++) begin
            if (adj[4*k +: 4] > 4'd4) begin
                adj[4*k +: 4] = adj[4*k +: 4] + 4'd3;
            end
        end
        if (start_i && !q.busy) begin
            d.busy = 1'b1;
            d.cnt  = CNT_W'(BIN_W);
            d.bin  = bin_i;
            d.bcd  = '0;
        end else if (q.busy) begin
            {d.bcd, d.bin} = {adj, q.bin} << 1;
            d.cnt          = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign bcd_o  = q.bcd;
endmodule

// File: rtl/telem_uart_tx.sv
module telem_uart_tx #(
    parameter int DIV = 434
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] data_i,
    output logic       busy_o,
    output logic       txd_o
);
    localparam int DIV_W    = $clog2(DIV + 1);
    localparam int FRAME_W  = 10;

    typedef struct packed {
        logic               busy;
        logic [3:0]         bitn;
        logic [DIV_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
    } utx_t;

    utx_t q, d;

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (start_i) begin
                d.busy = 1'b1;
                d.sh   = {1'b1, data_i, 1'b0};
                d.cnt  = DIV_W'(DIV - 1);
                d.bitn = '0;
            end
        end else if (q.cnt == '0) begin
            d.cnt = DIV_W'(DIV - 1);
            d.sh  = {1'b1, q.sh[FRAME_W-1:1]};
            if (q.bitn == 4'(FRAME_W - 1)) begin
                d.busy = 1'b0;
            end else begin
                d.bitn = q.bitn + 1'b1;
            end
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, bitn: '0, cnt: '0, sh: '1};
        end else begin
            q <= d;
        end
    end

    assign busy_o = q.busy;
    assign txd_o  = q.busy ? q.sh[0] : 1'b1;
endmodule

// File: rtl/telem_heartbeat.sv
module telem_heartbeat #(
    parameter int ON_CYC = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_i,
    output logic hb_o
);
    localparam int CNT_W = $clog2(ON_CYC + 1);

    typedef struct packed {
        logic             pps_q;
        logic [CNT_W-1:0] cnt;
    } hb_t;

    hb_t q, d;

    always_comb begin
        d       = q;
        d.pps_q = pps_i;
        if (pps_i && !q.pps_q) begin
            d.cnt = CNT_W'(ON_CYC);
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign hb_o = (q.cnt != '0);
endmodule

// File: rtl/osc_telemetry.sv
module osc_telemetry
    import telem_pkg::*;
#(
    parameter int BAUD_DIV  = 434,
    parameter int HB_ON_CYC = 5_000_000,
    parameter int DAC_W     = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             report_req,
    input  logic [VAL_W-1:0] phase_count,
    input  logic [DAC_W-1:0] dac_code,
    input  logic [2:0]       filt_mode,
    input  logic             unlocked,
    input  logic             deglitched,
    input  logic             pps,
    output logic             txd,
    output logic             heartbeat
);
    localparam int IDX_W = $clog2(NUM_VALS);
    localparam int CHR_W = $clog2(LINE_LEN);

    typedef struct packed {
        seq_state_e                       st;
        logic [IDX_W-1:0]                 val_idx;
        logic [CHR_W-1:0]                 chr_idx;
        logic [NUM_VALS-1:0][VAL_W-1:0]   snap;
        logic [NUM_VALS-1:0][VAL_W-1:0]   pend_vals;
        logic                             pend;
        logic [BCD_W-1:0]                 digits;
    } seq_t;

    seq_t q, d;

    logic             tx_busy;
    logic             tx_start;
    logic [7:0]       tx_byte;
    logic             conv_start;
    logic [VAL_W-1:0] conv_val;
    logic             conv_done;
    logic [BCD_W-1:0] conv_bcd;
    logic [VAL_W-1:0] status_val;
    logic [VAL_W-1:0] dac_top;
    logic             unused_dac_lsb;

    assign dac_top        = dac_code[DAC_W-1 -: VAL_W];
    assign unused_dac_lsb = ^dac_code[DAC_W-VAL_W-1:0];
    assign status_val     = VAL_W'(filt_mode)
                          + (unlocked   ? VAL_W'(100) : '0)
                          + (deglitched ? VAL_W'(10)  : '0);

    // character chosen by position within the current line
    always_comb begin
        if (q.chr_idx < CHR_W'(NUM_DIG)) begin
            tx_byte = ASC_ZERO + {4'b0000,
                      q.digits[4*(NUM_DIG-1-int'(q.chr_idx)) +: 4]};
        end else if (q.chr_idx == CHR_W'(NUM_DIG)) begin
            tx_byte = ASC_CR;
        end else begin
            tx_byte = ASC_LF;
        end
    end

    always_comb begin
        d          = q;
        tx_start   = 1'b0;
        conv_start = 1'b0;
        conv_val   = q.snap[q.val_idx];
        case (q.st)
            SQ_IDLE: begin
                if (q.pend) begin
                    d.snap    = q.pend_vals;
                    d.pend    = 1'b0;
                    d.val_idx = '0;
                    d.st      = SQ_CONV;
                end
            end
            SQ_CONV: begin
                conv_start = 1'b1;
                d.st       = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (conv_done) begin
                    d.digits  = conv_bcd;
                    d.chr_idx = '0;
                    d.st      = SQ_CHAR;
                end
            end
            SQ_CHAR: begin
                if (!tx_busy) begin
                    tx_start = 1'b1;
                    if (q.chr_idx == CHR_W'(LINE_LEN - 1)) begin
                        if (q.val_idx == IDX_W'(NUM_VALS - 1)) begin
                            d.st = SQ_IDLE;
                        end else begin
                            d.val_idx = q.val_idx + 1'b1;
                            d.st      = SQ_CONV;
                        end
                    end else begin
                        d.chr_idx = q.chr_idx + 1'b1;
                    end
                end
            end
            default: d.st = SQ_IDLE;
        endcase
        // a new request always lands in the pending slot, newest wins
        if (report_req) begin
            d.pend_vals = {status_val, dac_top, phase_count};
            d.pend      = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    telem_bin2dec #(
        .BIN_W (VAL_W),
        .DIG   (NUM_DIG)
    ) u_conv (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (conv_start),
        .bin_i   (conv_val),
        .done_o  (conv_done),
        .bcd_o   (conv_bcd)
    );

    telem_uart_tx #(
        .DIV (BAUD_DIV)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tx_start),
        .data_i  (tx_byte),
        .busy_o  (tx_busy),
        .txd_o   (txd)
    );

    telem_heartbeat #(
        .ON_CYC (HB_ON_CYC)
    ) u_hb (
        .clk   (clk),
        .rst_n (rst_n),
        .pps_i (pps),
        .hb_o  (heartbeat)
    );
endmodule

// File: rtl/telem_chk.sv
module telem_chk
    import telem_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pps,
    input logic             heartbeat,
    input logic             txd,
    input logic             tx_busy,
    input logic             tx_start,
    input logic [7:0]       tx_byte,
    input logic             conv_done,
    input logic [BCD_W-1:0] conv_bcd
);
    // R6
    txd_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    // R6
    tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> tx_busy);

    // R2
    tx_char_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (tx_byte inside {[8'h30:8'h39], 8'h0D, 8'h0A}));

    // R10
    hb_on_pps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pps) |=> heartbeat);

    for (genvar gi = 0; gi < NUM_DIG; gi++) begin : g_dig
        // R3
        bcd_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            conv_done |-> (conv_bcd[4*gi +: 4] <= 4'd9));
    end
endmodule

bind osc_telemetry telem_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pps       (pps),
    .heartbeat (heartbeat),
    .txd       (txd),
    .tx_busy   (tx_busy),
    .tx_start  (tx_start),
    .tx_byte   (tx_byte),
    .conv_done (conv_done),
    .conv_bcd  (conv_bcd)
);

// File: tb/tb_osc_telemetry.sv
`timescale 1ns/1ps
module tb_osc_telemetry;
    localparam int DIV   = 4;
    localparam int HB_ON = 20;
    localparam int LINE  = 7;
    localparam int MSG   = 3 * LINE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        report_req = 1'b0;
    logic [15:0] phase_count = '0;
    logic [17:0] dac_code = '0;
    logic [2:0]  filt_mode = '0;
    logic        unlocked = 1'b0;
    logic        deglitched = 1'b0;
    logic        pps = 1'b0;
    logic        txd;
    logic        heartbeat;

    int checks = 0;
    int errors = 0;
    int frame_err = 0;
    int rx_n = 0;
    logic [7:0] rx_buf [0:1023];
    bit finished = 0;

    always #10 clk = ~clk;

    osc_telemetry #(
        .BAUD_DIV  (DIV),
        .HB_ON_CYC (HB_ON),
        .DAC_W     (18)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .report_req  (report_req),
        .phase_count (phase_count),
        .dac_code    (dac_code),
        .filt_mode   (filt_mode),
        .unlocked    (unlocked),
        .deglitched  (deglitched),
        .pps         (pps),
        .txd         (txd),
        .heartbeat   (heartbeat)
    );

    // serial receiver: mid-bit sampling on falling clock edges
    initial begin
        logic [7:0] bv;
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                repeat (DIV / 2) @(negedge clk);
                if (txd !== 1'b0) frame_err++;
                for (int b = 0; b < 8; b++) begin
                    repeat (DIV) @(negedge clk);
                    bv[b] = txd;
                end
                repeat (DIV) @(negedge clk);
                if (txd !== 1'b1) frame_err++;
                if (rx_n < 1024) rx_buf[rx_n] = bv;
                rx_n++;
            end
        end
    end

    task automatic check_val(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic check_line(input int base, input int exp_v, input string tag);
        int v;
        bit ok;
        v  = 0;
        ok = 1;
        if (base + LINE > rx_n) begin
            ok = 0;
            v  = -1;
        end else begin
            for (int k = 0; k < 5; k++) begin
                if (rx_buf[base+k] < 8'h30 || rx_buf[base+k] > 8'h39) ok = 0;
                v = v * 10 + (int'(rx_buf[base+k]) - 48);
            end
            if (rx_buf[base+5] != 8'h0D || rx_buf[base+6] != 8'h0A) ok = 0;
        end
        checks++;
        if (!ok || v != exp_v) begin
            errors++;
            $display("FAIL %s line at %0d actual %0d expected %0d (format ok=%0d)",
                     tag, base, v, exp_v, ok);
        end
    endtask

    task automatic issue(input logic [15:0] ph, input logic [17:0] dac,
                         input logic [2:0] m, input logic u, input logic g);
        @(negedge clk);
        phase_count = ph;
        dac_code    = dac;
        filt_mode   = m;
        unlocked    = u;
        deglitched  = g;
        report_req  = 1'b1;
        @(negedge clk);
        report_req  = 1'b0;
        // R7: scramble inputs after the capture cycle
        phase_count = ~ph;
        dac_code    = ~dac;
        filt_mode   = ~m;
        unlocked    = ~u;
        deglitched  = ~g;
    endtask

    task automatic wait_bytes(input int target);
        for (int i = 0; i < 8000 && rx_n < target; i++) @(negedge clk);
    endtask

    task automatic expect_msg(input int base, input logic [15:0] ph,
                              input logic [17:0] dac, input logic [2:0] m,
                              input logic u, input logic g, input string tag);
        check_line(base,          int'(ph), {tag, " R2 R3 phase"});
        check_line(base + LINE,   int'(dac >> 2), {tag, " R4 dac"});
        check_line(base + 2*LINE, int'(m) + 100 * int'(u) + 10 * int'(g),
                   {tag, " R5 status"});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        finish_run();
    end

    initial begin
        int base;
        int hc;
        bit steady;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 txd after reset", int'(txd), 1);
        check_val("R1 heartbeat after reset", int'(heartbeat), 0);

        // exhaustive sweep of the status fields
        for (int m = 0; m < 8; m++) begin
            for (int u = 0; u < 2; u++) begin
                for (int g = 0; g < 2; g++) begin
                    logic [15:0] ph;
                    logic [17:0] dc;
                    ph   = 16'(m * 8191 + u * 37 + g * 5);
                    dc   = 18'(m * 32771 + u * 4099 + g * 129);
                    base = rx_n;
                    issue(ph, dc, 3'(m), u[0], g[0]);
                    wait_bytes(base + MSG);
                    expect_msg(base, ph, dc, 3'(m), u[0], g[0], "sweep R7");
                end
            end
        end

        // converter extremes
        base = rx_n; issue(16'd0,     18'h00003, 3'd0, 1'b0, 1'b0);
        wait_bytes(base + MSG); expect_msg(base, 16'd0, 18'h00003, 3'd0, 1'b0, 1'b0, "zeros");
        base = rx_n; issue(16'd65535, 18'h3FFFF, 3'd7, 1'b1, 1'b1);
        wait_bytes(base + MSG); expect_msg(base, 16'd65535, 18'h3FFFF, 3'd7, 1'b1, 1'b1, "max");
        base = rx_n; issue(16'd9,     18'h20000, 3'd1, 1'b0, 1'b1);
        wait_bytes(base + MSG); expect_msg(base, 16'd9, 18'h20000, 3'd1, 1'b0, 1'b1, "msb");
        base = rx_n; issue(16'd10000, 18'h1FFFF, 3'd2, 1'b1, 1'b0);
        wait_bytes(base + MSG); expect_msg(base, 16'd10000, 18'h1FFFF, 3'd2, 1'b1, 1'b0, "carry");
        base = rx_n; issue(16'd59999, 18'h27100, 3'd5, 1'b0, 1'b0);
        wait_bytes(base + MSG); expect_msg(base, 16'd59999, 18'h27100, 3'd5, 1'b0, 1'b0, "nines");

        // R8: request during a message is sent next
        base = rx_n;
        issue(16'd1234, 18'h01000, 3'd3, 1'b0, 1'b1);
        repeat (200) @(negedge clk);
        issue(16'd4321, 18'h2F000, 3'd6, 1'b1, 1'b0);
        wait_bytes(base + 2 * MSG);
        expect_msg(base,       16'd1234, 18'h01000, 3'd3, 1'b0, 1'b1, "R8 first");
        expect_msg(base + MSG, 16'd4321, 18'h2F000, 3'd6, 1'b1, 1'b0, "R8 queued");

        // R8: newest pending request replaces an older one
        repeat (50) @(negedge clk);
        base = rx_n;
        issue(16'd111, 18'h00400, 3'd1, 1'b0, 1'b0);
        repeat (100) @(negedge clk);
        issue(16'd222, 18'h00800, 3'd2, 1'b0, 1'b0);
        repeat (100) @(negedge clk);
        issue(16'd333, 18'h00C00, 3'd4, 1'b1, 1'b1);
        wait_bytes(base + 2 * MSG);
        expect_msg(base,       16'd111, 18'h00400, 3'd1, 1'b0, 1'b0, "R8 head");
        expect_msg(base + MSG, 16'd333, 18'h00C00, 3'd4, 1'b1, 1'b1, "R8 latest");

        // R9: quiet line without requests
        base   = rx_n;
        steady = 1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) steady = 0;
        end
        check_val("R8 R9 no extra bytes", rx_n - base, 0);
        check_val("R9 txd held high", int'(steady), 1);
        check_val("R6 framing errors", frame_err, 0);

        // R10: single pulse
        hc = 0;
        @(negedge clk); pps = 1'b1;
        for (int i = 1; i <= 100; i++) begin
            @(negedge clk);
            if (heartbeat) hc++;
            if (i == 1) pps = 1'b0;
        end
        check_val("R10 single window", hc, HB_ON);

        // R11: retrigger seven cycles after the first edge
        hc = 0;
        @(negedge clk); pps = 1'b1;
        for (int i = 1; i <= 100; i++) begin
            @(negedge clk);
            if (heartbeat) hc++;
            if (i == 1) pps = 1'b0;
            if (i == 7) pps = 1'b1;
            if (i == 8) pps = 1'b0;
        end
        check_val("R11 retrigger window", hc, 7 + HB_ON);

        // R11: held level gives one window
        hc = 0;
        @(negedge clk); pps = 1'b1;
        for (int i = 1; i <= 100; i++) begin
            @(negedge clk);
            if (heartbeat) hc++;
            if (i == 50) pps = 1'b0;
        end
        check_val("R11 held level window", hc, HB_ON);
        check_val("R10 dark without pulses", int'(heartbeat), 0);

        finish_run();
    end
endmodule